// File: doc/BRIEF.md
# Dual-Mode J-K / D Storage Bank with Preload

This block is a bank of independent single-bit storage elements. Each element chooses, on every clock edge, whether it acts as a plain D flip-flop or as a J-K flip-flop. A per-bit mode input makes that choice, so a state machine can switch an element between the two behaviours from one cycle to the next. Each element also has its own asynchronous preset and clear, and a load control that captures a separate data bit on the clock edge. The load control is how an external value is synchronised into the element.

The bank is meant to sit behind logic that produces the per-bit control terms. Clock selection, output gating and the logic that forms J, K and the controls belong to the surrounding design. A synchronous, active-high power-on reset clears every element to 0. The number of elements is set by a parameter.

Top module: `jkd_bank`

## Requirements
- R1: With mode low (and no load, reset, preset or clear), a rising clock edge stores `jd_i` into `q_o`.
- R2: With mode high (and no load, reset, preset or clear), a rising edge acts on the pair {J,K} = {`jd_i`,`k_i`} as follows: 2'b00 holds, 2'b01 clears to 0, 2'b10 sets to 1, 2'b11 inverts `q_o`.
- R3: The mode input is sampled on each edge, so alternating it on consecutive edges alternates between D and J-K behaviour with no extra latency.
- R4: A high preset bit forces its `q_o` bit to 1 without waiting for a clock edge, and keeps it at 1 across edges while it stays high.
- R5: A high clear bit, with preset low, forces its `q_o` bit to 0 without waiting for a clock edge, and keeps it at 0 across edges.
- R6: When preset and clear are high together, `q_o` is 1.
- R7: `rst` high at a rising edge clears every element to 0. It takes priority over load and next-state logic but yields to preset and clear.
- R8: With load high and no reset, preset or clear, a rising edge stores `ld_data_i` into `q_o`, whatever the mode, J/D and K bits are.
- R9: Each bit of the bank follows only its own control bits. Different bits in different modes in the same cycle do not affect one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high power-on clear |
| mode_i | input | WIDTH | Per bit: 0 = D behaviour, 1 = J-K behaviour |
| jd_i | input | WIDTH | D input in D mode, J input in J-K mode |
| k_i | input | WIDTH | K input, used only in J-K mode |
| pre_i | input | WIDTH | Asynchronous active-high preset |
| clr_i | input | WIDTH | Asynchronous active-high clear |
| ld_i | input | WIDTH | Load control, active high |
| ld_data_i | input | WIDTH | Data captured when load is high |
| q_o | output | WIDTH | Stored state, one bit per element |

## Verification
Each synchronous result (D capture, J-K action, load, reset) appears one register stage after the edge that samples it. The bench therefore drives inputs just after a falling edge and compares `q_o` at the following falling edge, which lies half a period after the edge that made the change. Preset and clear results are due with no clock at all. They are checked 1 ns after the preset or clear is driven, before the next rising edge, and again at the falling edge after that rising edge to confirm they override the clock. Preset and clear are only released from a cycle in which both are being dropped together, so every assertion of either one starts from an idle state.

// File: rtl/jkd_pkg.sv
package jkd_pkg;

  // J-K action selected by the pair {J,K}
  typedef enum logic [1:0] {
    JK_HOLD   = 2'b00,
    JK_CLEAR  = 2'b01,
    JK_SET    = 2'b10,
    JK_INVERT = 2'b11
  } jk_act_e;

  function automatic logic jk_result(input jk_act_e act, input logic cur);
    logic r;
    case (act)
      JK_HOLD:   r = cur;
      JK_CLEAR:  r = 1'b0;
      JK_SET:    r = 1'b1;
      default:   r = ~cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/jkd_next.sv
module jkd_next
  import jkd_pkg::*;
(
  input  logic cur_q,
  input  logic mode,
  input  logic jd,
  input  logic k,
  input  logic ld,
  input  logic ld_data,
  output logic nxt_q
);

  jk_act_e act;

  always_comb begin
    act = jk_act_e'({jd, k});
    if (ld)
      nxt_q = ld_data;
    else if (!mode)
      nxt_q = jd;
    else
      nxt_q = jk_result(act, cur_q);
  end

endmodule

// File: rtl/jkd_cell.sv
module jkd_cell (
  input  logic clk,
  input  logic rst,
  input  logic mode_i,
  input  logic jd_i,
  input  logic k_i,
  input  logic pre_i,
  input  logic clr_i,
  input  logic ld_i,
  input  logic ld_data_i,
  output logic q_o
);

  logic q_r;
  logic nxt;

  jkd_next u_next (
    .cur_q   (q_r),
    .mode    (mode_i),
    .jd      (jd_i),
    .k       (k_i),
    .ld      (ld_i),
    .ld_data (ld_data_i),
    .nxt_q   (nxt)
  );

  // preset beats clear; both beat the synchronous reset and the clock path
  always_ff @(posedge clk or posedge pre_i or posedge clr_i) begin
    if (pre_i)
      q_r <= 1'b1;
    else if (clr_i)
      q_r <= 1'b0;
    else if (rst)
      q_r <= 1'b0;
    else
      q_r <= nxt;
  end

  assign q_o = q_r;

  logic quiet;
  assign quiet = !pre_i && !clr_i;

  assert_d_capture_R1: assert property (@(posedge clk) disable iff (rst)
    (quiet && !ld_i && !mode_i) |=> (pre_i || clr_i || q_r == $past(jd_i)));

  assert_jk_invert_R2: assert property (@(posedge clk) disable iff (rst)
    (quiet && !ld_i && mode_i && jd_i && k_i) |=> (pre_i || clr_i || q_r == !$past(q_r)));

  assert_jk_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (quiet && !ld_i && mode_i && !jd_i && !k_i) |=> (pre_i || clr_i || $stable(q_r)));

  assert_preset_high_R4: assert property (@(posedge clk) disable iff (rst)
    pre_i |-> q_r);

  assert_clear_low_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !pre_i) |-> !q_r);

  assert_both_high_R6: assert property (@(posedge clk) disable iff (rst)
    (pre_i && clr_i) |-> q_r);

  assert_reset_clears_R7: assert property (@(posedge clk) disable iff (pre_i || clr_i)
    rst |=> !q_r);

  assert_load_capture_R8: assert property (@(posedge clk) disable iff (rst)
    (quiet && ld_i) |=> (pre_i || clr_i || q_r == $past(ld_data_i)));

endmodule

// File: rtl/jkd_bank.sv
module jkd_bank #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] mode_i,
  input  logic [WIDTH-1:0] jd_i,
  input  logic [WIDTH-1:0] k_i,
  input  logic [WIDTH-1:0] pre_i,
  input  logic [WIDTH-1:0] clr_i,
  input  logic [WIDTH-1:0] ld_i,
  input  logic [WIDTH-1:0] ld_data_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_cell
    jkd_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .mode_i    (mode_i[g]),
      .jd_i      (jd_i[g]),
      .k_i       (k_i[g]),
      .pre_i     (pre_i[g]),
      .clr_i     (clr_i[g]),
      .ld_i      (ld_i[g]),
      .ld_data_i (ld_data_i[g]),
      .q_o       (q_o[g])
    );
  end

endmodule

// File: tb/jkd_bank_bench.sv
module jkd_bank_bench;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] mode_i, jd_i, k_i, pre_i, clr_i, ld_i, ld_data_i, q_o;
  logic [W-1:0] exp_q;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  jkd_bank #(.WIDTH(W)) u_jkd_bank (
    .clk(clk), .rst(rst), .mode_i(mode_i), .jd_i(jd_i), .k_i(k_i),
    .pre_i(pre_i), .clr_i(clr_i), .ld_i(ld_i), .ld_data_i(ld_data_i), .q_o(q_o)
  );

  function automatic logic model_bit(input logic cur, input logic r, input logic m,
                                     input logic d, input logic k, input logic l,
                                     input logic ldd);
    if (r) return 1'b0;
    if (l) return ldd;
    if (!m) return d;
    case ({d, k})
      2'b00:   return cur;
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      default: return ~cur;
    endcase
  endfunction

  function automatic string tag_of(input logic p, input logic c, input logic r,
                                   input logic l, input logic m);
    if (p && c) return "R6";
    if (p) return "R4";
    if (c) return "R5";
    if (r) return "R7";
    if (l) return "R8";
    if (m) return "R2";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: q_o=%b expected %b at %0t", tag, got, want, $time);
    end
  endtask

  task automatic check_bits(input logic [W-1:0] got, input logic [W-1:0] want);
    for (int i = 0; i < W; i++) begin
      checks++;
      if (got[i] !== want[i]) begin
        fails++;
        $display("FAIL %s: bit %0d q=%b expected %b at %0t",
                 tag_of(pre_i[i], clr_i[i], rst, ld_i[i], mode_i[i]), i, got[i], want[i], $time);
      end
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic cycle(input logic r, input logic [W-1:0] m, input logic [W-1:0] d,
                       input logic [W-1:0] k, input logic [W-1:0] p, input logic [W-1:0] c,
                       input logic [W-1:0] l, input logic [W-1:0] ldd);
    logic [W-1:0] nxt;
    rst = r; mode_i = m; jd_i = d; k_i = k; pre_i = p; clr_i = c; ld_i = l; ld_data_i = ldd;
    #1;
    for (int i = 0; i < W; i++)
      if (p[i]) exp_q[i] = 1'b1;
      else if (c[i]) exp_q[i] = 1'b0;
    if ((p | c) != '0) check_bits(q_o, exp_q);  // R4 R5 R6: no clock needed
    for (int i = 0; i < W; i++)
      nxt[i] = (p[i] || c[i]) ? exp_q[i]
             : model_bit(exp_q[i], r, m[i], d[i], k[i], l[i], ldd[i]);
    @(negedge clk);
    exp_q = nxt;
    #1;
    check_bits(q_o, exp_q);
  endtask

  initial begin
    logic [W-1:0] prev_async;
    void'($urandom(32'd1234));
    rst = 1'b1; mode_i = '0; jd_i = '0; k_i = '0; pre_i = '0; clr_i = '0;
    ld_i = '0; ld_data_i = '0; exp_q = '0;
    @(negedge clk); #1;
    check("R7", q_o, '0);

    // R1: D capture
    cycle(0, 4'b0000, 4'b1010, 4'b1111, 0, 0, 0, 0);
    // R2: J-K set / clear / hold / invert on different bits
    cycle(0, 4'b1111, 4'b0110, 4'b0011, 0, 0, 0, 0);
    cycle(0, 4'b1111, 4'b1111, 4'b1111, 0, 0, 0, 0);
    cycle(0, 4'b1111, 4'b0000, 4'b0000, 0, 0, 0, 0);
    // R3: mode alternates on consecutive edges for bit 0
    cycle(0, 4'b0000, 4'b0001, 4'b0000, 0, 0, 0, 0);
    check("R3", q_o[0], 1'b1);
    cycle(0, 4'b0001, 4'b0001, 4'b0001, 0, 0, 0, 0);
    check("R3", q_o[0], 1'b0);
    cycle(0, 4'b0000, 4'b0000, 4'b0001, 0, 0, 0, 0);
    check("R3", q_o[0], 1'b0);
    // R9: bit0 JK invert, bit1 D=1, bit2 load 0, bit3 JK hold, all at once
    cycle(0, 4'b1001, 4'b0011, 4'b0001, 0, 0, 4'b0100, 4'b0000);
    check("R9", q_o, {exp_q[3], 1'b0, 1'b1, 1'b1});
    // R8: load overrides a J-K invert
    cycle(0, 4'b1111, 4'b1111, 4'b1111, 0, 0, 4'b1111, 4'b0110);
    check("R8", q_o, 4'b0110);
    // R6: both async high forces 1, held over an edge that would clear
    cycle(0, 4'b0000, 4'b0000, 0, 4'b1111, 4'b1111, 0, 0);
    check("R6", q_o, 4'b1111);
    cycle(0, 4'b0000, 4'b0000, 0, 0, 0, 0, 0);
    // R7 yields to preset; R5 clear beats load
    cycle(1, 0, 0, 0, 4'b0001, 0, 0, 0);
    check("R7", q_o, 4'b0001);
    cycle(0, 0, 4'b1111, 0, 0, 4'b1111, 4'b1111, 4'b1111);
    check("R5", q_o, 4'b0000);

    prev_async = '0;
    for (int n = 0; n < 2000; n++) begin
      logic [W-1:0] p, c;
      logic r;
      p = '0; c = '0;
      if (prev_async == '0) begin
        for (int i = 0; i < W; i++) begin
          p[i] = ($urandom % 10) == 0;
          c[i] = ($urandom % 10) == 0;
        end
      end
      prev_async = p | c;
      r = ($urandom % 32) == 0;
      cycle(r, W'($urandom), W'($urandom), W'($urandom), p, c,
            W'($urandom) & W'($urandom) & W'($urandom), W'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule